// File: doc/BRIEF.md
# Sixteen-Bit Accumulator ALU

This block is the arithmetic and logic stage of a small accumulator machine. It is purely combinational: it reads the accumulator value and a second operand, and it uses a four-bit operation code to pick one of nine functions. It returns a sixteen-bit result in the same evaluation, together with a zero indication and a sign indication taken from that result. The enclosing datapath registers the result into the accumulator when its sequencer says so. The ALU holds no state and has no clock.

The operation codes run from 1 to 9, in the same order as the machine's opcodes. Code 0 and codes 10 to 15 return the accumulator unchanged, so an idle control word causes no change. The multiplier keeps only a narrow slice of the product, because the machine has no register for a high product word. The divider returns a truncated unsigned quotient. Because the block is a single combinational stage with no transfer at its edge, it has no valid/ready handshake and no back-pressure.

Top module: `acc_alu16`

## Requirements
- R1: With select 4'b0001 the result is (A + B) modulo 2^16, where A is the accumulator input and B is the operand input.
- R2: With select 4'b0010 the result is (A - B) modulo 2^16, so a smaller A wraps around.
- R3: With select 4'b0011 the result is A AND B bitwise, and with select 4'b0100 it is A OR B bitwise.
- R4: With select 4'b0101 the result is the bitwise inverse of B, and A has no effect on it.
- R5: With select 4'b0110 the result is A shifted right by one place, with a zero entering bit 15.
- R6: With select 4'b0111 the result is A shifted left by one place, with a zero entering bit 0.
- R7: With select 4'b1000 the result is the low 8 bits of the unsigned product A*B, placed in bits 7..0, with bits 15..8 set to zero.
- R8: With select 4'b1001 and B not zero, the result is the unsigned quotient A/B rounded toward zero.
- R9: With select 4'b1001 and B equal to zero, the result is 16'hFFFF.
- R10: With select 4'b0000 or any select from 4'b1010 to 4'b1111, the result equals A.
- R11: The zero output is 1 exactly when the result is 16'h0000.
- R12: The sign output always equals bit 15 of the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 16 | Accumulator operand (A) |
| opnd_i | input | 16 | Second operand (B) |
| op_sel_i | input | 4 | Operation select code |
| res_o | output | 16 | Result |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result bit 15 |

## Verification
The assertions are immediate checks that are evaluated whenever the inputs change. They assume that the three inputs are settled, two-state values, so a transient glitch between input updates must not occur. The bench meets this by changing all inputs together, from a single process, half a cycle away from the point where it samples. Random selects cover the full four-bit range, so every unused code is exercised. Zero operands are injected on purpose, so the divide-by-zero case is reached often.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned SEL_W = 4;

  localparam logic [SEL_W-1:0] OP_ADD = 4'd1;
  localparam logic [SEL_W-1:0] OP_SUB = 4'd2;
  localparam logic [SEL_W-1:0] OP_AND = 4'd3;
  localparam logic [SEL_W-1:0] OP_OR  = 4'd4;
  localparam logic [SEL_W-1:0] OP_INV = 4'd5;
  localparam logic [SEL_W-1:0] OP_SHR = 4'd6;
  localparam logic [SEL_W-1:0] OP_SHL = 4'd7;
  localparam logic [SEL_W-1:0] OP_MUL = 4'd8;
  localparam logic [SEL_W-1:0] OP_DIV = 4'd9;

  typedef enum logic [2:0] {
    GRP_PASS,
    GRP_ARITH,
    GRP_LOGIC,
    GRP_MULDIV
  } op_grp_e;

  function automatic op_grp_e grp_of(input logic [SEL_W-1:0] sel);
    case (sel)
      OP_ADD, OP_SUB:                 return GRP_ARITH;
      OP_AND, OP_OR, OP_INV,
      OP_SHR, OP_SHL:                 return GRP_LOGIC;
      OP_MUL, OP_DIV:                 return GRP_MULDIV;
      default:                        return GRP_PASS;
    endcase
  endfunction
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] b_eff;

  // Two's complement subtraction through an inverted operand and carry in.
  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int unsigned W     = 16,
  parameter int unsigned SEL_W = 4
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [W-1:0]     y_o
);
  import acc_alu_pkg::*;

  logic [W-1:0] shr_v;
  logic [W-1:0] shl_v;

  // One-place logical shifts, built bit by bit.
  for (genvar i = 0; i < W; i++) begin : g_shift
    if (i == W-1) begin : g_top
      assign shr_v[i] = 1'b0;
    end else begin : g_mid_r
      assign shr_v[i] = a_i[i+1];
    end
    if (i == 0) begin : g_bot
      assign shl_v[i] = 1'b0;
    end else begin : g_mid_l
      assign shl_v[i] = a_i[i-1];
    end
  end

  always_comb begin
    case (sel_i)
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_INV:  y_o = ~b_i;
      OP_SHR:  y_o = shr_v;
      OP_SHL:  y_o = shl_v;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
  parameter int unsigned W      = 16,
  parameter int unsigned PROD_W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         div_i,
  output logic [W-1:0] y_o
);
  localparam int unsigned PAD_W = W - PROD_W;

  logic [PROD_W-1:0] prod_lo;
  logic [W-1:0]      quot;
  logic              b_zero;

  always_comb begin
    // Low product bits depend only on the low operand bits.
    prod_lo = a_i[PROD_W-1:0] * b_i[PROD_W-1:0];
    b_zero  = (b_i == '0);
    quot    = b_zero ? '1 : (a_i / b_i);
    y_o     = div_i ? quot : {{PAD_W{1'b0}}, prod_lo};
  end
endmodule

// File: rtl/acc_alu16.sv
module acc_alu16 #(
  parameter int unsigned W      = 16,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned PROD_W = 8
) (
  input  logic [W-1:0]     acc_i,
  input  logic [W-1:0]     opnd_i,
  input  logic [SEL_W-1:0] op_sel_i,
  output logic [W-1:0]     res_o,
  output logic             zero_o,
  output logic             neg_o
);
  import acc_alu_pkg::*;

  logic [W-1:0] arith_y;
  logic [W-1:0] logic_y;
  logic [W-1:0] md_y;
  op_grp_e      grp;

  acc_alu_addsub #(.W(W)) u_addsub (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .sub_i (op_sel_i == OP_SUB),
    .sum_o (arith_y)
  );

  acc_alu_logic #(.W(W), .SEL_W(SEL_W)) u_logic (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .sel_i (op_sel_i),
    .y_o   (logic_y)
  );

  acc_alu_muldiv #(.W(W), .PROD_W(PROD_W)) u_muldiv (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .div_i (op_sel_i == OP_DIV),
    .y_o   (md_y)
  );

  always_comb begin
    grp = grp_of(op_sel_i);
    case (grp)
      GRP_ARITH:  res_o = arith_y;
      GRP_LOGIC:  res_o = logic_y;
      GRP_MULDIV: res_o = md_y;
      default:    res_o = acc_i;
    endcase
    zero_o = ~|res_o;
    neg_o  = res_o[W-1];
  end
endmodule

// File: rtl/acc_alu16_chk.sv
module acc_alu16_chk #(
  parameter int unsigned W      = 16,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned PROD_W = 8
) (
  input logic [W-1:0]     acc_i,
  input logic [W-1:0]     opnd_i,
  input logic [SEL_W-1:0] op_sel_i,
  input logic [W-1:0]     res_o,
  input logic             zero_o,
  input logic             neg_o
);
  always_comb begin
    if (op_sel_i == 4'd5) AST_INV_OPND: assert (res_o == ~opnd_i); // R4
    if (op_sel_i == 4'd6) AST_SHR_FILL: assert (res_o[W-1] == 1'b0 && res_o[W-2:0] == acc_i[W-1:1]); // R5
    if (op_sel_i == 4'd7) AST_SHL_FILL: assert (res_o[0] == 1'b0 && res_o[W-1:1] == acc_i[W-2:0]); // R6
    if (op_sel_i == 4'd8) AST_MUL_HIGH_CLEAR: assert (res_o[W-1:PROD_W] == '0); // R7
    if (op_sel_i == 4'd9 && opnd_i == '0) AST_DIV_BY_ZERO: assert (res_o == '1); // R9
    if (op_sel_i == 4'd9 && opnd_i != '0) AST_DIV_BOUND: assert (res_o <= acc_i); // R8
    if (op_sel_i == 4'd0 || op_sel_i >= 4'd10) AST_PASS_THRU: assert (res_o == acc_i); // R10
    AST_ZERO_FLAG: assert (zero_o == (res_o == '0)); // R11
    AST_SIGN_FLAG: assert (neg_o == res_o[W-1]); // R12
  end
endmodule

bind acc_alu16 acc_alu16_chk #(.W(W), .SEL_W(SEL_W), .PROD_W(PROD_W)) u_chk (
  .acc_i    (acc_i),
  .opnd_i   (opnd_i),
  .op_sel_i (op_sel_i),
  .res_o    (res_o),
  .zero_o   (zero_o),
  .neg_o    (neg_o)
);

// File: tb/acc_alu16_tb_top.sv
module acc_alu16_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] acc_i  = '0;
  logic [15:0] opnd_i = '0;
  logic [3:0]  op_sel_i = '0;
  logic [15:0] res_o;
  logic        zero_o;
  logic        neg_o;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk; // 50 MHz

  acc_alu16 dut_i (
    .acc_i(acc_i), .opnd_i(opnd_i), .op_sel_i(op_sel_i),
    .res_o(res_o), .zero_o(zero_o), .neg_o(neg_o)
  );

  function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b,
                                        input logic [3:0] s);
    logic [31:0] p;
    case (s)
      4'd1: return a + b;
      4'd2: return a - b;
      4'd3: return a & b;
      4'd4: return a | b;
      4'd5: return ~b;
      4'd6: return {1'b0, a[15:1]};
      4'd7: return {a[14:0], 1'b0};
      4'd8: begin p = {16'd0, a} * {16'd0, b}; return {8'd0, p[7:0]}; end
      4'd9: return (b == 0) ? 16'hFFFF : a / b;
      default: return a;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s, input logic [15:0] b);
    case (s)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3, 4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9: return (b == 0) ? "R9" : "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [3:0] s);
    logic [15:0] e;
    @(posedge clk);
    acc_i = a; opnd_i = b; op_sel_i = s;
    @(negedge clk);
    e = model(a, b, s);
    total++;
    if (res_o !== e) begin
      bad++;
      $display("FAIL %s sel=%0d a=%h b=%h actual=%h expected=%h", req_of(s, b), s, a, b, res_o, e);
    end
    total++;
    if (zero_o !== (e == 16'd0)) begin
      bad++;
      $display("FAIL R11 actual=%b expected=%b", zero_o, (e == 16'd0));
    end
    total++;
    if (neg_o !== e[15]) begin
      bad++;
      $display("FAIL R12 actual=%b expected=%b", neg_o, e[15]);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h1F2E;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle state: select 0 with zero operands gives zero result (R10, R11)
    apply(16'h0000, 16'h0000, 4'd0);
    apply(16'hFFFF, 16'h0001, 4'd1);   // R1 wrap to zero
    apply(16'h1234, 16'h4321, 4'd1);   // R1
    apply(16'h0000, 16'h0001, 4'd2);   // R2 wrap to FFFF
    apply(16'h5555, 16'h5555, 4'd2);   // R2 zero result
    apply(16'hF0F0, 16'h3C3C, 4'd3);   // R3 and
    apply(16'hF0F0, 16'h3C3C, 4'd4);   // R3 or
    apply(16'hAAAA, 16'h00FF, 4'd5);   // R4
    apply(16'h1234, 16'h00FF, 4'd5);   // R4 A ignored
    apply(16'h8001, 16'h0000, 4'd6);   // R5
    apply(16'h8001, 16'h0000, 4'd7);   // R6
    apply(16'd12,   16'd3,    4'd8);   // R7 small product
    apply(16'h00FF, 16'h00FF, 4'd8);   // R7 truncation
    apply(16'h1234, 16'h0100, 4'd8);   // R7 high bits only -> zero
    apply(16'd12,   16'd3,    4'd9);   // R8 exact
    apply(16'd13,   16'd4,    4'd9);   // R8 truncated
    apply(16'hFFFF, 16'h0001, 4'd9);   // R8
    apply(16'h1234, 16'h0000, 4'd9);   // R9
    apply(16'h0000, 16'h0000, 4'd9);   // R9
    for (int s = 10; s < 16; s++) apply(16'h9ABC, 16'h1111, 4'(s)); // R10
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = ($urandom % 8 == 0) ? 16'd0 : 16'($urandom);
      if ($urandom % 4 == 0) b = b & 16'h000F;
      apply(a, b, 4'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule